// File: doc/BRIEF.md
# Overlapping Register Window File

This block holds the general registers of a small load/store core as a set of register windows arranged in a ring. Every instruction names one of 32 logical registers. The block turns that number into a physical storage slot using the current window pointer. Each window has three areas: incoming arguments, private locals and outgoing arguments. One bank of globals is shared by every window. The outgoing area of one window is the same storage as the incoming area of the next window. A caller therefore hands arguments to its callee by writing them, and no data is ever moved.

A procedure call moves the current window pointer forward by one window, and a return moves it back by one. A second pointer marks the boundary of the windows that have been spilled to memory. A call that would land on that boundary raises an overflow trap, and a return that would land on it raises an underflow trap. A trapping call or return does not move the window. The trap handler moves the boundary pointer one window at a time through two step inputs, once it has spilled or refilled a window. The block has two combinational read ports and one write port that is written on the clock edge.

Top module: `regwin_file`

## Requirements
- R1: After reset the current window pointer is 0, the boundary pointer is 7 (the last window), every register reads 0 and both trap outputs are low.
- R2: Logical registers 0 to 7 are globals and map to the same storage whatever the current window is.
- R3: Logical registers 8 to 15 are the incoming area of the current window and 24 to 31 are its outgoing area. Outgoing register 24+n of window k is the same storage as incoming register 8+n of window (k+1) mod 8, and this includes the wrap from window 7 to window 0.
- R4: Logical registers 16 to 23 are locals that belong to one window only. A write to a local in one window never changes a local of another window.
- R5: A call without a trap moves the current window pointer to (cwp+1) mod 8. A return without a trap moves it to (cwp-1) mod 8.
- R6: A call while (cwp+1) mod 8 equals the boundary pointer drives the overflow trap high in that same cycle and leaves the current window pointer unchanged.
- R7: A return while (cwp-1) mod 8 equals the boundary pointer drives the underflow trap high in that same cycle and leaves the current window pointer unchanged.
- R8: The spill step moves the boundary pointer forward by one window and the fill step moves it back by one window, both modulo 8. When both steps are asserted in the same cycle the boundary pointer does not change.
- R9: Reads are combinational. A write takes effect at the rising clock edge, so a read of the register being written in the same cycle returns the old value.
- R10: When call and return are asserted in the same cycle, the call is carried out and the return is ignored. A trap output is high only in a cycle in which its own request is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Procedure call request |
| ret_i | input | 1 | Procedure return request |
| spill_step_i | input | 1 | Advance the boundary pointer after a window is spilled |
| fill_step_i | input | 1 | Move the boundary pointer back after a window is refilled |
| rd0_addr_i | input | 5 | Logical register for read port 0 |
| rd0_data_o | output | 32 | Read port 0 data |
| rd1_addr_i | input | 5 | Logical register for read port 1 |
| rd1_data_o | output | 32 | Read port 1 data |
| we_i | input | 1 | Write enable |
| wr_addr_i | input | 5 | Logical register to write |
| wr_data_i | input | 32 | Write data |
| ovf_trap_o | output | 1 | Window overflow trap |
| unf_trap_o | output | 1 | Window underflow trap |
| cwp_o | output | 3 | Current window pointer |
| swp_o | output | 3 | Boundary (saved window) pointer |

## Verification
The address mapping is tested with three patterns. A global is written in one window and read from another. An outgoing register is written and then read as an incoming register after a call, and in the other direction after a return. A local is written in two windows that follow each other. Together these patterns separate shared storage, overlapped storage and private storage. Call and return runs go all the way around the ring, so both traps are reached and the wrap from window 7 to window 0 is crossed, including an argument handed across that wrap. Single-cycle patterns cover a read of the register being written, call and return asserted together, and both step inputs asserted together. These show the ordering rules apart from the normal path.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    // logical register areas, selected by the two top address bits
    typedef enum logic [1:0] {
        AREA_GLOB  = 2'd0,
        AREA_IN    = 2'd1,
        AREA_LOCAL = 2'd2,
        AREA_OUT   = 2'd3
    } area_e;

endpackage

// File: rtl/regwin_map.sv
module regwin_map
    import regwin_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int AREA = 8,
    localparam int CW  = $clog2(NWIN),
    localparam int OW  = $clog2(AREA),
    localparam int AW  = OW + 2,
    localparam int NPHYS = AREA + NWIN * 2 * AREA,
    localparam int PW  = $clog2(NPHYS)
) (
    input  logic [CW-1:0] cwp_i,
    input  logic [AW-1:0] laddr_i,
    output logic [PW-1:0] paddr_o
);

    area_e           area;
    logic [OW-1:0]   off;
    logic [CW-1:0]   nxt_win;
    int              slot;

    always_comb begin
        area    = area_e'(laddr_i[AW-1 -: 2]);
        off     = laddr_i[OW-1:0];
        nxt_win = cwp_i + 1'b1;
        unique case (area)
            AREA_GLOB:  slot = int'(off);
            AREA_IN:    slot = AREA + int'(cwp_i) * 2 * AREA + int'(off);
            AREA_LOCAL: slot = AREA + int'(cwp_i) * 2 * AREA + AREA + int'(off);
            default:    slot = AREA + int'(nxt_win) * 2 * AREA + int'(off);
        endcase
        paddr_o = PW'(slot);
    end

    // R3
    always_comb begin
        map_range_chk: assert (slot < NPHYS);
    end

endmodule

// File: rtl/regwin_ptrs.sv
module regwin_ptrs #(
    parameter int NWIN = 8,
    localparam int CW  = $clog2(NWIN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          spill_step_i,
    input  logic          fill_step_i,
    output logic          ovf_trap_o,
    output logic          unf_trap_o,
    output logic [CW-1:0] cwp_o,
    output logic [CW-1:0] swp_o
);

    typedef struct packed {
        logic [CW-1:0] cwp;
        logic [CW-1:0] swp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [CW-1:0] call_tgt, ret_tgt;
    logic          ovf, unf;

    always_comb begin
        ptr_d    = ptr_q;
        call_tgt = ptr_q.cwp + 1'b1;
        ret_tgt  = ptr_q.cwp - 1'b1;
        ovf      = call_i && (call_tgt == ptr_q.swp);
        unf      = ret_i && !call_i && (ret_tgt == ptr_q.swp);
        if (call_i) begin
            if (!ovf) ptr_d.cwp = call_tgt;
        end else if (ret_i) begin
            if (!unf) ptr_d.cwp = ret_tgt;
        end
        if (spill_step_i && !fill_step_i)
            ptr_d.swp = ptr_q.swp + 1'b1;
        else if (fill_step_i && !spill_step_i)
            ptr_d.swp = ptr_q.swp - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q.cwp <= '0;
            ptr_q.swp <= CW'(NWIN - 1);
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ovf_trap_o = ovf;
    assign unf_trap_o = unf;
    assign cwp_o      = ptr_q.cwp;
    assign swp_o      = ptr_q.swp;

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_trap_o |=> $stable(cwp_o));

    // R7
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_trap_o |=> $stable(cwp_o));

    // R5
    call_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !ovf_trap_o) |=> (cwp_o == CW'($past(cwp_o) + 1'b1)));

    // R5
    ret_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !call_i && !unf_trap_o) |=> (cwp_o == CW'($past(cwp_o) - 1'b1)));

    // R8
    swp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spill_step_i == fill_step_i) |=> $stable(swp_o));

    // R10
    trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_trap_o && unf_trap_o));

endmodule

// File: rtl/regwin_store.sv
module regwin_store #(
    parameter int NPHYS = 136,
    parameter int DW    = 32,
    localparam int PW   = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] ra0_i,
    input  logic [PW-1:0] ra1_i,
    output logic [DW-1:0] rd0_o,
    output logic [DW-1:0] rd1_o,
    input  logic          we_i,
    input  logic [PW-1:0] wa_i,
    input  logic [DW-1:0] wd_i
);

    logic [DW-1:0] mem_d [NPHYS];
    logic [DW-1:0] mem_q [NPHYS];

    always_comb begin
        mem_d = mem_q;
        if (we_i) mem_d[wa_i] = wd_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rd0_o = mem_q[ra0_i];
    assign rd1_o = mem_q[ra1_i];

    // R9
    wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (mem_q[$past(wa_i)] == $past(wd_i)));

endmodule

// File: rtl/regwin_file.sv
module regwin_file #(
    parameter int NWIN = 8,
    parameter int AREA = 8,
    parameter int DW   = 32,
    localparam int CW    = $clog2(NWIN),
    localparam int AW    = $clog2(AREA) + 2,
    localparam int NPHYS = AREA + NWIN * 2 * AREA,
    localparam int PW    = $clog2(NPHYS),
    localparam int NPORT = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          spill_step_i,
    input  logic          fill_step_i,
    input  logic [AW-1:0] rd0_addr_i,
    output logic [DW-1:0] rd0_data_o,
    input  logic [AW-1:0] rd1_addr_i,
    output logic [DW-1:0] rd1_data_o,
    input  logic          we_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [DW-1:0] wr_data_i,
    output logic          ovf_trap_o,
    output logic          unf_trap_o,
    output logic [CW-1:0] cwp_o,
    output logic [CW-1:0] swp_o
);

    logic [CW-1:0] cwp;
    logic [AW-1:0] laddr [NPORT];
    logic [PW-1:0] paddr [NPORT];

    assign laddr[0] = rd0_addr_i;
    assign laddr[1] = rd1_addr_i;
    assign laddr[2] = wr_addr_i;

    regwin_ptrs #(.NWIN(NWIN)) u_ptrs (
        .clk          (clk),
        .rst_n        (rst_n),
        .call_i       (call_i),
        .ret_i        (ret_i),
        .spill_step_i (spill_step_i),
        .fill_step_i  (fill_step_i),
        .ovf_trap_o   (ovf_trap_o),
        .unf_trap_o   (unf_trap_o),
        .cwp_o        (cwp),
        .swp_o        (swp_o)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_map
        regwin_map #(.NWIN(NWIN), .AREA(AREA)) u_map (
            .cwp_i   (cwp),
            .laddr_i (laddr[g]),
            .paddr_o (paddr[g])
        );
    end

    regwin_store #(.NPHYS(NPHYS), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .ra0_i (paddr[0]),
        .ra1_i (paddr[1]),
        .rd0_o (rd0_data_o),
        .rd1_o (rd1_data_o),
        .we_i  (we_i),
        .wa_i  (paddr[2]),
        .wd_i  (wr_data_i)
    );

    assign cwp_o = cwp;

endmodule

// File: tb/tb_regwin_file.sv
module tb_regwin_file;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_i = 1'b0, ret_i = 1'b0, spill_step_i = 1'b0, fill_step_i = 1'b0;
    logic [4:0]  rd0_addr_i = '0, rd1_addr_i = '0, wr_addr_i = '0;
    logic [31:0] rd0_data_o, rd1_data_o, wr_data_i = '0;
    logic        we_i = 1'b0;
    logic        ovf_trap_o, unf_trap_o;
    logic [2:0]  cwp_o, swp_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    regwin_file dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
        .spill_step_i(spill_step_i), .fill_step_i(fill_step_i),
        .rd0_addr_i(rd0_addr_i), .rd0_data_o(rd0_data_o),
        .rd1_addr_i(rd1_addr_i), .rd1_data_o(rd1_data_o),
        .we_i(we_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o),
        .cwp_o(cwp_o), .swp_o(swp_o)
    );

    always #4 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // one clock with control requests; traps sampled before the edge
    task automatic pulse(input bit c, input bit r, input bit s, input bit f,
                         output logic ov, output logic un);
        call_i = c; ret_i = r; spill_step_i = s; fill_step_i = f;
        #1;
        ov = ovf_trap_o; un = unf_trap_o;
        @(posedge clk); #1;
        call_i = 0; ret_i = 0; spill_step_i = 0; fill_step_i = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        we_i = 1; wr_addr_i = a; wr_data_i = d;
        @(posedge clk); #1;
        we_i = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        rd1_addr_i = a; #1; d = rd1_data_o;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 cwp", 32'(cwp_o), 0);
        check("R1 swp", 32'(swp_o), 7);
        rd(5'd5, d);  check("R1 global", d, 0);
        rd(5'd20, d); check("R1 local", d, 0);
        check("R1 traps", {30'd0, ovf_trap_o, unf_trap_o}, 0);
    endtask

    task automatic t_globals();
        logic ov, un; logic [31:0] d;
        wr(5'd3, 32'hA0A0_0003);
        pulse(1, 0, 0, 0, ov, un);
        check("R2 cwp after call", 32'(cwp_o), 1);
        rd(5'd3, d); check("R2 global seen in window 1", d, 32'hA0A0_0003);
        pulse(0, 1, 0, 0, ov, un);
        check("R5 ret back", 32'(cwp_o), 0);
    endtask

    task automatic t_overlap();
        logic ov, un; logic [31:0] d;
        wr(5'd26, 32'hB00B_0026);
        pulse(1, 0, 0, 0, ov, un);
        rd(5'd10, d); check("R3 out->in", d, 32'hB00B_0026);
        wr(5'd12, 32'hC00C_0012);
        pulse(0, 1, 0, 0, ov, un);
        rd(5'd28, d); check("R3 in->caller out", d, 32'hC00C_0012);
    endtask

    task automatic t_locals();
        logic ov, un; logic [31:0] d;
        wr(5'd17, 32'hD00D_0017);
        pulse(1, 0, 0, 0, ov, un);
        rd(5'd17, d); check("R4 callee local fresh", d, 0);
        wr(5'd17, 32'hE00E_0017);
        pulse(0, 1, 0, 0, ov, un);
        rd(5'd17, d); check("R4 caller local kept", d, 32'hD00D_0017);
    endtask

    task automatic t_same_cycle();
        rd0_addr_i = 5'd5;
        we_i = 1; wr_addr_i = 5'd5; wr_data_i = 32'hF00F_0005;
        #1;
        check("R9 old value before edge", rd0_data_o, 0);
        @(posedge clk); #1;
        we_i = 0;
        check("R9 new value after edge", rd0_data_o, 32'hF00F_0005);
    endtask

    task automatic t_unf_reset();
        logic ov, un;
        #1; check("R10 no unf without ret", 32'(unf_trap_o), 0);
        pulse(0, 1, 0, 0, ov, un);
        check("R7 unf raised", 32'(un), 1);
        check("R7 cwp held", 32'(cwp_o), 0);
    endtask

    task automatic t_ovf_wrap();
        logic ov, un; logic [31:0] d;
        for (int i = 1; i <= 6; i++) begin
            pulse(1, 0, 0, 0, ov, un);
            check("R5 call step", 32'(cwp_o), 32'(i));
            check("R6 no ovf", 32'(ov), 0);
        end
        pulse(1, 0, 0, 0, ov, un);
        check("R6 ovf raised", 32'(ov), 1);
        check("R6 cwp held", 32'(cwp_o), 6);
        pulse(0, 0, 1, 0, ov, un);
        check("R8 spill wraps", 32'(swp_o), 0);
        pulse(1, 0, 0, 0, ov, un);
        check("R5 cwp 7", 32'(cwp_o), 7);
        wr(5'd24, 32'h1234_5678);
        pulse(1, 0, 0, 0, ov, un);
        check("R6 ovf at 7", 32'(ov), 1);
        pulse(0, 0, 1, 0, ov, un);
        check("R8 spill", 32'(swp_o), 1);
        pulse(1, 0, 0, 0, ov, un);
        check("R5 wrap 7->0", 32'(cwp_o), 0);
        rd(5'd8, d); check("R3 overlap across wrap", d, 32'h1234_5678);
    endtask

    task automatic t_ret_fill();
        logic ov, un;
        for (int i = 0; i < 6; i++) pulse(0, 1, 0, 0, ov, un);
        check("R5 ret wraps to 2", 32'(cwp_o), 2);
        pulse(0, 1, 0, 0, ov, un);
        check("R7 unf raised", 32'(un), 1);
        check("R7 cwp held", 32'(cwp_o), 2);
        pulse(0, 0, 0, 1, ov, un);
        check("R8 fill", 32'(swp_o), 0);
        pulse(0, 1, 0, 0, ov, un);
        check("R7 ret after fill", 32'(cwp_o), 1);
        pulse(0, 0, 1, 1, ov, un);
        check("R8 both steps hold", 32'(swp_o), 0);
    endtask

    task automatic t_both();
        logic ov, un;
        pulse(1, 1, 0, 0, ov, un);
        check("R10 call wins", 32'(cwp_o), 2);
        check("R10 no unf", 32'(un), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #2;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        t_reset();
        t_globals();
        t_overlap();
        t_locals();
        t_same_cycle();
        t_unf_reset();
        t_ovf_wrap();
        t_ret_fill();
        t_both();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule